// File: doc/BRIEF.md
# Shared-Pin GPIO Scan Data Register

This block is a scan data register, eight bits wide by default, that lets a secondary scan port lend some of its pins to general-purpose I/O. With the default parameters, two of the port's pins become outputs driven from the low register bits: bit 1 drives the port's data-out pin and bit 0 drives its mode-select pin. A third pin, the port's data-in pin, is reported as an input in bit 2. The register sits on the scan chain when the register-select input is high. Pin levels enter the register on the Capture-DR strobe, bits move through it least significant bit first during Shift-DR, and the output bits are copied to the pins on the Update-DR strobe.

The GPIO function follows a mode-enable input that an external mode register drives. That input is high only when the mode register holds the value one. An enable state machine has three states: `EN_OFF` (pins keep their scan role), `EN_ON` (GPIO active) and `EN_LOCKED` (cleared by a reset-type instruction). It moves `EN_OFF→EN_ON` when the mode enable is high. It moves `EN_ON→EN_OFF` when the mode enable drops. Any state moves `→EN_LOCKED` on a reset-type instruction pulse. It moves `EN_LOCKED→EN_OFF` once the mode enable is low. A scan-phase state machine has the states `PH_IDLE`, `PH_CAPTURE` and `PH_SHIFT`. It moves `PH_IDLE→PH_CAPTURE` on a selected capture and `PH_CAPTURE/PH_SHIFT→PH_SHIFT` on a selected shift. It returns `→PH_IDLE` on any update strobe or on an unselected capture. An update is applied only if a selected capture opened the scan. An asynchronous active-low test reset clears everything.

Top module: `spio_dr_top`

## Requirements
- R1: While `trst_n` is low, `pin_oe_o` and `pin_out_o` are all zero and `tdo` is 0. The first selected scan after reset reads `{0…0, pin_in_i, 0, 0}`.
- R2: `pin_oe_o` is all ones from the first TCK edge at which `mode_en` is sampled high. It is all zeros from the first edge at which `mode_en` is sampled low.
- R3: A selected capture loads bits DR_W-1..N_OUT+1 with 0 and bit N_OUT with `pin_in_i`. It loads bits N_OUT-1..0 with `pin_fb_i` when GPIO is on and with 0 when GPIO is off.
- R4: `tdo` shows register bit 0. Each selected Shift-DR edge moves the register one place toward bit 0 and enters `tdi` at bit DR_W-1.
- R5: `pin_out_o` changes only at a selected Update-DR edge. It then takes the shifted bits N_OUT-1..0, and bits above them are ignored.
- R6: The output register resets to zero, so the pins drive logic 0 when GPIO is first enabled after reset.
- R7: A `rst_instr` pulse clears the output register and turns GPIO off. GPIO stays off until `mode_en` has been seen low and then high again.
- R8: Strobes with `sel` low change neither the register (`tdo` holds) nor the pins.
- R9: An Update-DR that follows no selected capture leaves the pins unchanged.
- R10: While GPIO is off, `pin_out_o` is held at zero, although updates still load the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| sel | input | 1 | This register is the selected data register |
| tdi | input | 1 | Serial scan input |
| mode_en | input | 1 | Mode register holds the GPIO-enable value |
| rst_instr | input | 1 | Reset-type instruction decoded (one-cycle pulse) |
| pin_in_i | input | 1 | Sensed level of the port's data-in pin |
| pin_fb_i | input | N_OUT | Sensed levels of the reused output pins |
| tdo | output | 1 | Serial scan output |
| pin_out_o | output | N_OUT | Pin output values |
| pin_oe_o | output | N_OUT | Pin output enables |

## Verification
The bench builds the block with the default DR_W of 8 and N_OUT of 2. With these values all 256 written register values can be swept, each paired with both input-pin levels, once with GPIO on and once with GPIO off. Because there are only two output pins, the bench's pad model can feed back every drive pattern. Each write's captured read-back is checked one scan later, and the pins are watched through every shift cycle, so ordering, ignored upper bits and the gating in the off state are all covered exhaustively.

// File: rtl/spio_pkg.sv
package spio_pkg;

    typedef enum logic [1:0] {
        EN_OFF    = 2'd0,
        EN_ON     = 2'd1,
        EN_LOCKED = 2'd2
    } en_state_t;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_CAPTURE = 2'd1,
        PH_SHIFT   = 2'd2
    } phase_t;

endpackage

// File: rtl/spio_enable_fsm.sv
module spio_enable_fsm
    import spio_pkg::*;
(
    input  logic tck,
    input  logic trst_n,
    input  logic mode_en,
    input  logic rst_instr,
    output logic gpio_on,
    output logic clear_reg
);

    en_state_t state_q;
    en_state_t state_d;

    // state register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            state_q <= EN_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EN_OFF: begin
                if (rst_instr)    state_d = EN_LOCKED;
                else if (mode_en) state_d = EN_ON;
            end
            EN_ON: begin
                if (rst_instr)     state_d = EN_LOCKED;
                else if (!mode_en) state_d = EN_OFF;
            end
            EN_LOCKED: begin
                if (!rst_instr && !mode_en) state_d = EN_OFF;
            end
            default: state_d = EN_OFF;
        endcase
    end

    // outputs
    always_comb begin
        gpio_on   = (state_q == EN_ON);
        clear_reg = rst_instr;
    end

endmodule

// File: rtl/spio_shift_path.sv
module spio_shift_path
    import spio_pkg::*;
#(
    parameter int DR_W  = 8,
    parameter int N_OUT = 2
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             sel,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic             tdi,
    input  logic [DR_W-1:0]  cap_vec,
    output logic             tdo,
    output logic [N_OUT-1:0] load_bits,
    output logic             load_ok
);

    phase_t            phase_q;
    phase_t            phase_d;
    logic [DR_W-1:0]   sr_q;
    logic [DR_W-1:0]   sr_d;

    // state register and shift register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            phase_q <= PH_IDLE;
            sr_q    <= '0;
        end else begin
            phase_q <= phase_d;
            sr_q    <= sr_d;
        end
    end

    // transitions and data path
    always_comb begin
        phase_d = phase_q;
        sr_d    = sr_q;
        if (capture_dr) begin
            if (sel) begin
                phase_d = PH_CAPTURE;
                sr_d    = cap_vec;
            end else begin
                phase_d = PH_IDLE;
            end
        end else if (shift_dr) begin
            if (sel) begin
                unique case (phase_q)
                    PH_IDLE:    phase_d = PH_IDLE;
                    PH_CAPTURE: phase_d = PH_SHIFT;
                    PH_SHIFT:   phase_d = PH_SHIFT;
                    default:    phase_d = PH_IDLE;
                endcase
                sr_d = {tdi, sr_q[DR_W-1:1]};
            end
        end else if (update_dr) begin
            phase_d = PH_IDLE;
        end
    end

    // outputs
    always_comb begin
        tdo       = sr_q[0];
        load_bits = sr_q[N_OUT-1:0];
        load_ok   = update_dr && !capture_dr && !shift_dr && sel
                    && (phase_q != PH_IDLE);
    end

endmodule

// File: rtl/spio_pin_drive.sv
module spio_pin_drive #(
    parameter int DR_W  = 8,
    parameter int N_OUT = 2
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             load,
    input  logic             clear,
    input  logic [N_OUT-1:0] load_val,
    input  logic             gpio_on,
    input  logic [N_OUT-1:0] pin_fb,
    input  logic             pin_in,
    output logic [N_OUT-1:0] pin_o,
    output logic [N_OUT-1:0] pin_oe,
    output logic [DR_W-1:0]  cap_vec
);

    localparam int IN_BIT = N_OUT;

    logic [N_OUT-1:0] out_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            out_q <= '0;
        end else if (clear) begin
            out_q <= '0;
        end else if (load) begin
            out_q <= load_val;
        end
    end

    for (genvar i = 0; i < N_OUT; i++) begin : g_pin
        always_comb begin
            pin_o[i]   = gpio_on & out_q[i];
            pin_oe[i]  = gpio_on;
            cap_vec[i] = gpio_on & pin_fb[i];
        end
    end

    always_comb cap_vec[IN_BIT] = pin_in;

    for (genvar j = IN_BIT + 1; j < DR_W; j++) begin : g_pad
        always_comb cap_vec[j] = 1'b0;
    end

endmodule

// File: rtl/spio_dr_top.sv
module spio_dr_top #(
    parameter int DR_W  = 8,
    parameter int N_OUT = 2
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic             sel,
    input  logic             tdi,
    input  logic             mode_en,
    input  logic             rst_instr,
    input  logic             pin_in_i,
    input  logic [N_OUT-1:0] pin_fb_i,
    output logic             tdo,
    output logic [N_OUT-1:0] pin_out_o,
    output logic [N_OUT-1:0] pin_oe_o
);

    logic             gpio_on;
    logic             clear_reg;
    logic             load_ok;
    logic [N_OUT-1:0] load_bits;
    logic [DR_W-1:0]  cap_vec;

    spio_enable_fsm u_en (
        .tck       (tck),
        .trst_n    (trst_n),
        .mode_en   (mode_en),
        .rst_instr (rst_instr),
        .gpio_on   (gpio_on),
        .clear_reg (clear_reg)
    );

    spio_shift_path #(.DR_W(DR_W), .N_OUT(N_OUT)) u_sp (
        .tck        (tck),
        .trst_n     (trst_n),
        .sel        (sel),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .tdi        (tdi),
        .cap_vec    (cap_vec),
        .tdo        (tdo),
        .load_bits  (load_bits),
        .load_ok    (load_ok)
    );

    spio_pin_drive #(.DR_W(DR_W), .N_OUT(N_OUT)) u_pd (
        .tck      (tck),
        .trst_n   (trst_n),
        .load     (load_ok),
        .clear    (clear_reg),
        .load_val (load_bits),
        .gpio_on  (gpio_on),
        .pin_fb   (pin_fb_i),
        .pin_in   (pin_in_i),
        .pin_o    (pin_out_o),
        .pin_oe   (pin_oe_o),
        .cap_vec  (cap_vec)
    );

endmodule

// File: rtl/spio_dr_chk.sv
module spio_dr_chk #(
    parameter int N_OUT = 2
) (
    input logic             tck,
    input logic             trst_n,
    input logic             capture_dr,
    input logic             shift_dr,
    input logic             update_dr,
    input logic             sel,
    input logic             mode_en,
    input logic             rst_instr,
    input logic             tdo,
    input logic [N_OUT-1:0] pin_out_o,
    input logic [N_OUT-1:0] pin_oe_o
);

    always @(posedge tck) begin
        if (!trst_n) begin
            AST_RESET_QUIET: assert (pin_oe_o == '0 && pin_out_o == '0); // R1
        end
    end

    AST_MODE_OFF: assert property (@(posedge tck) disable iff (!trst_n)
        !mode_en |=> pin_oe_o == '0); // R2

    AST_OFF_QUIET: assert property (@(posedge tck) disable iff (!trst_n)
        pin_oe_o == '0 |-> pin_out_o == '0); // R10

    AST_OUT_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        (pin_oe_o == '1 && !(update_dr && sel) && !rst_instr && mode_en)
        |=> $stable(pin_out_o)); // R5

    AST_RST_INSTR_OFF: assert property (@(posedge tck) disable iff (!trst_n)
        rst_instr |=> pin_oe_o == '0); // R7

    AST_UNSEL_TDO: assert property (@(posedge tck) disable iff (!trst_n)
        (!sel || !(capture_dr || shift_dr)) |=> $stable(tdo)); // R8

endmodule

bind spio_dr_top spio_dr_chk #(.N_OUT(N_OUT)) u_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .sel        (sel),
    .mode_en    (mode_en),
    .rst_instr  (rst_instr),
    .tdo        (tdo),
    .pin_out_o  (pin_out_o),
    .pin_oe_o   (pin_oe_o)
);

// File: tb/tb_spio_dr_top.sv
`timescale 1ns/1ps
module tb_spio_dr_top;

    localparam int DR_W  = 8;
    localparam int N_OUT = 2;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, sel = 1'b0;
    logic tdi = 1'b0, mode_en = 1'b0, rst_instr = 1'b0, pin_in_i = 1'b0;
    logic [N_OUT-1:0] pin_fb_i;
    logic tdo;
    logic [N_OUT-1:0] pin_out_o, pin_oe_o;
    logic [N_OUT-1:0] ext_lvl = 2'b10;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    // bench model state
    logic             en_m  = 1'b0;
    logic [N_OUT-1:0] out_m = '0;

    always #2 tck = ~tck;

    // pad model: driven pins read back their drive, others the external level
    for (genvar i = 0; i < N_OUT; i++) begin : g_pad
        assign pin_fb_i[i] = pin_oe_o[i] ? pin_out_o[i] : ext_lvl[i];
    end

    spio_dr_top #(.DR_W(DR_W), .N_OUT(N_OUT)) dut (
        .tck(tck), .trst_n(trst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .sel(sel), .tdi(tdi), .mode_en(mode_en),
        .rst_instr(rst_instr), .pin_in_i(pin_in_i), .pin_fb_i(pin_fb_i),
        .tdo(tdo), .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N_OUT-1:0] exp_pins();
        return en_m ? out_m : '0;
    endfunction

    task automatic check_pins(input string tag);
        chk(pin_out_o == exp_pins(), tag, int'(pin_out_o), int'(exp_pins()));
        chk(pin_oe_o == (en_m ? '1 : '0), tag, int'(pin_oe_o), en_m ? 3 : 0);
    endtask

    // one scan: capture, DR_W shifts, update; returns bits shifted out
    task automatic scan(input logic sel_cs, input logic sel_up,
                        input logic [DR_W-1:0] din, output logic [DR_W-1:0] dout);
        logic [N_OUT-1:0] pins_before;
        logic             tdo_before;
        pins_before = pin_out_o;
        sel = sel_cs;
        capture_dr = 1'b1;
        @(negedge tck);
        capture_dr = 1'b0;
        shift_dr = 1'b1;
        tdo_before = tdo;
        for (int i = 0; i < DR_W; i++) begin
            dout[i] = tdo;
            tdi = din[i];
            if (!sel_cs) chk(tdo == tdo_before, "R8 tdo held unselected", tdo, tdo_before);
            chk(pin_out_o == pins_before, "R5 pins stable during scan",
                int'(pin_out_o), int'(pins_before));
            @(negedge tck);
        end
        shift_dr = 1'b0;
        sel = sel_up;
        update_dr = 1'b1;
        @(negedge tck);
        update_dr = 1'b0;
        sel = 1'b0;
        if (sel_cs && sel_up) out_m = din[N_OUT-1:0];
    endtask

    task automatic set_mode(input logic v);
        mode_en = v;
        @(negedge tck);
        en_m = v;
    endtask

    initial begin : watchdog
        forever begin
            @(posedge tck);
            cycles++;
            if (cycles > 150000) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin : main
        logic [DR_W-1:0] rd;
        logic [DR_W-1:0] exp_rd;
        // R1: reset state
        #1;
        chk(pin_oe_o == '0 && pin_out_o == '0, "R1 reset pins", int'(pin_out_o), 0);
        chk(tdo == 1'b0, "R1 reset tdo", tdo, 0);
        @(negedge tck);
        @(negedge tck);
        trst_n = 1'b1;
        @(negedge tck);
        pin_in_i = 1'b1;
        scan(1'b1, 1'b1, 8'h00, rd);
        chk(rd == 8'h04, "R1 R3 first read disabled", rd, 8'h04);
        out_m = '0;

        // R2 R6: enable, default drive is 0
        set_mode(1'b1);
        check_pins("R2 R6 enable default drive");

        // sweep over all values and input levels, GPIO on then off
        for (int e = 1; e >= 0; e--) begin
            set_mode(e[0]);
            check_pins("R2 R10 mode change");
            for (int w = 0; w < 256; w++) begin
                for (int t = 0; t < 2; t++) begin
                    pin_in_i = t[0];
                    exp_rd = '0;
                    exp_rd[N_OUT] = t[0];
                    exp_rd[N_OUT-1:0] = en_m ? out_m : '0;
                    scan(1'b1, 1'b1, w[DR_W-1:0], rd);
                    chk(rd == exp_rd, "R3 R4 capture read", rd, exp_rd);
                    check_pins("R5 R10 update drive");
                end
            end
        end

        // R8: unselected scan changes nothing
        set_mode(1'b1);
        scan(1'b1, 1'b1, 8'h01, rd);
        check_pins("R8 setup");
        scan(1'b0, 1'b0, 8'hFE, rd);
        check_pins("R8 unselected pins");

        // R9: update without a selected capture
        scan(1'b1, 1'b0, 8'h02, rd);
        check_pins("R9 update unselected");
        sel = 1'b1;
        update_dr = 1'b1;
        @(negedge tck);
        update_dr = 1'b0;
        sel = 1'b0;
        @(negedge tck);
        check_pins("R9 lone update");
        chk(pin_out_o == 2'b01, "R9 pins kept", int'(pin_out_o), 1);

        // R7: reset instruction
        scan(1'b1, 1'b1, 8'h03, rd);
        chk(pin_out_o == 2'b11, "R7 setup", int'(pin_out_o), 3);
        rst_instr = 1'b1;
        @(negedge tck);
        rst_instr = 1'b0;
        chk(pin_oe_o == '0 && pin_out_o == '0, "R7 cleared", int'(pin_oe_o), 0);
        repeat (3) @(negedge tck);
        chk(pin_oe_o == '0, "R7 stays locked", int'(pin_oe_o), 0);
        set_mode(1'b0);
        out_m = '0;
        set_mode(1'b1);
        check_pins("R7 re-enable cleared");

        // R1: asynchronous reset while active
        scan(1'b1, 1'b1, 8'h03, rd);
        trst_n = 1'b0;
        #1;
        chk(pin_oe_o == '0 && pin_out_o == '0, "R1 async reset", int'(pin_oe_o), 0);
        chk(tdo == 1'b0, "R1 async tdo", tdo, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule